// File: doc/BRIEF.md
# Parallel Flash Command Interface

This block is the device side of a byte-wide parallel flash part that is driven through a write-command protocol. A host writes a command byte on a synchronous write strobe and reads bytes back on a read strobe. The same address can return three things, depending on the last command written: a stored array byte, an identifier or lock-configuration byte, or the status register.

Erase, byte program and lock clear each take two writes: a setup opcode and then a confirm or data write. They then run against a small on-chip memory model for a timed interval, and status bit 7 shows the device as busy during that interval. Parameters set the array size, the block size, the busy count, the identifier codes, whether the identifier offsets are shifted, and the lock state the device has after reset.

Top module: `pflash_cmd_if`

## Requirements
- R1: After reset the device is in array read mode and status reads 0x80. Array byte `a` holds `a[7:0] ^ INIT_XOR`, where INIT_XOR is 0xA5 by default. Block locks equal `INIT_BLK_LOCK` and the master lock equals `MASTER_LOCK`.
- R2: A read strobe in one cycle gives `rd_valid` high and the byte on `rdata` in the next cycle. Writing 0xFF selects array reads and writing 0x70 selects status reads.
- R3: Writing 0x90 selects identifier reads. Address `0<<ID_SHIFT` returns `MFR_CODE` and address `1<<ID_SHIFT` returns `DEV_CODE`. Addresses that carry no identifier or lock byte return 0x00.
- R4: In identifier mode, address `3<<ID_SHIFT` returns the master lock byte, and block offset `2<<ID_SHIFT` returns that block's lock byte. A lock byte is 0x01 when locked and 0x00 when clear.
- R5: The status byte has ready in bit 7, erase error in bit 5, program error in bit 4 and lock error in bit 1. Bits 6, 3, 2 and 0 always read 0.
- R6: Writing 0x50 clears bits 5, 4 and 1 and leaves the read mode unchanged.
- R7: Writing 0x20 and then 0xD0 erases the block addressed by the second write. The erase is busy for one cycle per block byte and leaves every byte of that block at 0xFF. Other blocks are not touched.
- R8: Writing 0x40 and then a data byte programs the addressed byte. After `BUSY_CYC` cycles it holds old AND data.
- R9: The second write of any sequence switches reads to status mode. While busy, bit 7 reads 0 and all writes are ignored.
- R10: If the second write of an erase or lock-clear sequence is not 0xD0, bits 5 and 4 are set, nothing runs, and ready stays 1.
- R11: Erasing a locked block sets bits 5 and 1, and programming a locked block sets bits 4 and 1. In both cases the array is left unchanged.
- R12: Writing 0x60 and then 0xD0 clears every block lock after `BUSY_CYC` cycles, if the master lock is clear. If the master lock is set, bits 5 and 1 are set and the locks stay as they were.
- R13: A write of an unknown opcode in idle changes neither the read mode nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Byte address for the write or read |
| wdata | input | 8 | Command or data byte |
| rdata | output | 8 | Read result, valid one cycle after `rd_en` |
| rd_valid | output | 1 | High in the cycle when `rdata` holds a read result |

## Verification
The bench reads the same addresses in array, identifier and status modes. A design that mixed up the read mux or the shifted identifier offsets would return the wrong byte at one of them.

It issues 0xFF in the middle of a program. A design that accepted writes while busy would drop back to array mode, so the status read taken after completion would not show 0x80.

It sends bad confirm bytes, and it targets locked blocks for both erase and program. A design that ran the operation anyway, or set the wrong error bits, is caught by a read of the status byte followed by a read of the array byte.

Lock clear is run on two instances, one with the master lock clear and one with it set. A design that ignored the master lock would show unlocked blocks on the second instance.

// File: rtl/pflash_pkg.sv
// Package: opcodes, status bit positions and the state types shared by the
// command sequencer, the status register and the top module.
package pflash_pkg;

    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OP_READ_ID    = 8'h90;
    localparam logic [7:0] OP_READ_STAT  = 8'h70;
    localparam logic [7:0] OP_CLR_STAT   = 8'h50;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_PROGRAM    = 8'h40;
    localparam logic [7:0] OP_LOCK_CLR   = 8'h60;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;

    localparam int ST_READY    = 7;
    localparam int ST_ERASE_ER = 5;
    localparam int ST_PROG_ER  = 4;
    localparam int ST_LOCK_ER  = 1;

    typedef enum logic [1:0] {
        MODE_ARRAY,
        MODE_ID,
        MODE_STATUS
    } rd_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ERASE_SETUP,
        S_PROG_SETUP,
        S_LOCK_SETUP,
        S_ERASE_BUSY,
        S_PROG_BUSY,
        S_LOCK_BUSY
    } seq_st_e;

endpackage

// File: rtl/pflash_array.sv
// Memory model: the byte array and the per-block lock bits.
// Assumes: program and erase never hit the same byte in the same cycle,
// which the sequencer guarantees because only one operation runs at a time.
// Program keeps old AND data; erase writes 0xFF; lock clear empties all locks.
module pflash_array #(
    parameter int          ADDR_W        = 10,
    parameter int          BLK_OFS_W     = 7,
    parameter logic [7:0]  INIT_XOR      = 8'hA5,
    parameter int          NUM_BLK       = 2 ** (ADDR_W - BLK_OFS_W),
    parameter logic [NUM_BLK-1:0] INIT_BLK_LOCK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_byte,
    input  logic                 prog_we,
    input  logic [ADDR_W-1:0]    prog_addr,
    input  logic [7:0]           prog_data,
    input  logic                 erase_we,
    input  logic [ADDR_W-1:0]    erase_addr,
    input  logic                 lock_clr,
    output logic [NUM_BLK-1:0]   blk_locked
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [7:0]         mem_q [DEPTH];
    logic [NUM_BLK-1:0] blk_lock_q;
    logic [7:0]         prog_old;

    // Current content of the byte being programmed.
    always_comb prog_old = mem_q[prog_addr];

    // Array storage: reset pattern, then AND-program and erase-to-FF.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'(i) ^ INIT_XOR;
            end
        end else begin
            if (prog_we)  mem_q[prog_addr]  <= prog_old & prog_data;
            if (erase_we) mem_q[erase_addr] <= 8'hFF;
        end
    end

    // Block lock bits: reset value from the parameter; only clearing exists.
    always_ff @(posedge clk) begin
        if (!rst_n)        blk_lock_q <= INIT_BLK_LOCK;
        else if (lock_clr) blk_lock_q <= '0;
    end

    // Array read port seen by the read multiplexer.
    always_comb rd_byte = mem_q[rd_addr];
    assign blk_locked = blk_lock_q;

    assert_prog_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> ((mem_q[$past(prog_addr)] & ~$past(prog_old)) == 8'h00));

    assert_erase_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_we |=> (mem_q[$past(erase_addr)] == 8'hFF));

    assert_lock_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lock_clr |=> (blk_lock_q == '0));

endmodule

// File: rtl/pflash_status.sv
// Status register: three sticky error bits plus a live ready bit.
// Assumes: set and clear requests never arrive in the same cycle (the
// clear opcode is only decoded in idle, and errors only arise on second writes).
module pflash_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       clr_err,
    input  logic       set_erase_err,
    input  logic       set_prog_err,
    input  logic       set_lock_err,
    output logic [7:0] status
);
    import pflash_pkg::*;

    logic erase_er_q, prog_er_q, lock_er_q;

    // Sticky error flags: set on request, cleared only by the clear opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_er_q <= 1'b0;
            prog_er_q  <= 1'b0;
            lock_er_q  <= 1'b0;
        end else if (clr_err) begin
            erase_er_q <= 1'b0;
            prog_er_q  <= 1'b0;
            lock_er_q  <= 1'b0;
        end else begin
            if (set_erase_err) erase_er_q <= 1'b1;
            if (set_prog_err)  prog_er_q  <= 1'b1;
            if (set_lock_err)  lock_er_q  <= 1'b1;
        end
    end

    // Byte assembly; suspend and supply bits are not modelled and stay 0.
    always_comb begin
        status              = 8'h00;
        status[ST_READY]    = ~busy;
        status[ST_ERASE_ER] = erase_er_q;
        status[ST_PROG_ER]  = prog_er_q;
        status[ST_LOCK_ER]  = lock_er_q;
    end

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_err || set_erase_err || set_prog_err || set_lock_err)
        |=> $stable({erase_er_q, prog_er_q, lock_er_q}));

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> ({erase_er_q, prog_er_q, lock_er_q} == 3'b000));

endmodule

// File: rtl/pflash_seq.sv
// Command sequencer: decodes bus writes, tracks the read mode, runs the
// two-write sequences and times each busy interval with one counter.
// Assumes: BUSY_CYC >= 1. Erase sweeps one block byte per cycle, so its busy
// time is the block size; program and lock clear last BUSY_CYC cycles.
module pflash_seq #(
    parameter int ADDR_W    = 10,
    parameter int BLK_OFS_W = 7,
    parameter int BUSY_CYC  = 8,
    parameter int NUM_BLK   = 2 ** (ADDR_W - BLK_OFS_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    input  logic [NUM_BLK-1:0]       blk_locked,
    input  logic                     master_locked,
    output pflash_pkg::rd_mode_e     mode,
    output logic                     busy,
    output logic                     prog_we,
    output logic [ADDR_W-1:0]        prog_addr,
    output logic [7:0]               prog_data,
    output logic                     erase_we,
    output logic [ADDR_W-1:0]        erase_addr,
    output logic                     lock_clr,
    output logic                     clr_err,
    output logic                     set_erase_err,
    output logic                     set_prog_err,
    output logic                     set_lock_err
);
    import pflash_pkg::*;

    localparam int BLK_BYTES = 2 ** BLK_OFS_W;
    localparam int BLK_IDX_W = ADDR_W - BLK_OFS_W;
    localparam int CNT_A     = $clog2(BUSY_CYC + 1);
    localparam int CNT_W     = (CNT_A > BLK_OFS_W + 1) ? CNT_A : BLK_OFS_W + 1;
    localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(BUSY_CYC - 1);
    localparam logic [CNT_W-1:0] ERS_LAST = CNT_W'(BLK_BYTES - 1);

    seq_st_e           st_q;
    rd_mode_e          mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [7:0]        tgt_data_q;

    logic             hit_locked;
    logic             is_confirm;
    logic             e_seq, e_lock, l_seq, l_lock, p_lock;
    logic [BLK_IDX_W-1:0] wr_blk;

    // Lock state of the block addressed by the current write.
    always_comb begin
        wr_blk     = addr[ADDR_W-1:BLK_OFS_W];
        hit_locked = blk_locked[wr_blk];
        is_confirm = (wdata == OP_CONFIRM);
    end

    // Error classification of a second write.
    always_comb begin
        e_seq  = (st_q == S_ERASE_SETUP) && wr_en && !is_confirm;
        e_lock = (st_q == S_ERASE_SETUP) && wr_en &&  is_confirm && hit_locked;
        l_seq  = (st_q == S_LOCK_SETUP)  && wr_en && !is_confirm;
        l_lock = (st_q == S_LOCK_SETUP)  && wr_en &&  is_confirm && master_locked;
        p_lock = (st_q == S_PROG_SETUP)  && wr_en &&  hit_locked;
        set_erase_err = e_seq | e_lock | l_seq | l_lock;
        set_prog_err  = e_seq | l_seq | p_lock;
        set_lock_err  = e_lock | l_lock | p_lock;
        clr_err       = (st_q == S_IDLE) && wr_en && (wdata == OP_CLR_STAT);
    end

    // Strobes into the memory model during each busy interval.
    always_comb begin
        busy       = (st_q == S_ERASE_BUSY) || (st_q == S_PROG_BUSY) ||
                     (st_q == S_LOCK_BUSY);
        prog_we    = (st_q == S_PROG_BUSY) && (cnt_q == OP_LAST);
        prog_addr  = tgt_addr_q;
        prog_data  = tgt_data_q;
        erase_we   = (st_q == S_ERASE_BUSY);
        erase_addr = {tgt_addr_q[ADDR_W-1:BLK_OFS_W], cnt_q[BLK_OFS_W-1:0]};
        lock_clr   = (st_q == S_LOCK_BUSY) && (cnt_q == OP_LAST);
        mode       = mode_q;
    end

    // Sequencer state, read mode, busy counter and captured target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= S_IDLE;
            mode_q     <= MODE_ARRAY;
            cnt_q      <= '0;
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (wr_en) begin
                        case (wdata)
                            OP_READ_ARRAY: mode_q <= MODE_ARRAY;
                            OP_READ_ID:    mode_q <= MODE_ID;
                            OP_READ_STAT:  mode_q <= MODE_STATUS;
                            OP_ERASE:      st_q   <= S_ERASE_SETUP;
                            OP_PROGRAM:    st_q   <= S_PROG_SETUP;
                            OP_LOCK_CLR:   st_q   <= S_LOCK_SETUP;
                            default:       ;
                        endcase
                    end
                end
                S_ERASE_SETUP: begin
                    if (wr_en) begin
                        mode_q     <= MODE_STATUS;
                        tgt_addr_q <= addr;
                        cnt_q      <= '0;
                        st_q       <= (is_confirm && !hit_locked) ? S_ERASE_BUSY : S_IDLE;
                    end
                end
                S_PROG_SETUP: begin
                    if (wr_en) begin
                        mode_q     <= MODE_STATUS;
                        tgt_addr_q <= addr;
                        tgt_data_q <= wdata;
                        cnt_q      <= '0;
                        st_q       <= hit_locked ? S_IDLE : S_PROG_BUSY;
                    end
                end
                S_LOCK_SETUP: begin
                    if (wr_en) begin
                        mode_q <= MODE_STATUS;
                        cnt_q  <= '0;
                        st_q   <= (is_confirm && !master_locked) ? S_LOCK_BUSY : S_IDLE;
                    end
                end
                S_ERASE_BUSY: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == ERS_LAST) st_q <= S_IDLE;
                end
                S_PROG_BUSY, S_LOCK_BUSY: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == OP_LAST) st_q <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assert_busy_freezes_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));

    assert_seq_err_no_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_erase_err && set_prog_err) |=> (!busy && mode_q == MODE_STATUS));

    assert_prog_target_unlocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> !blk_locked[prog_addr[ADDR_W-1:BLK_OFS_W]]);

    assert_busy_ends_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (st_q == S_IDLE));

endmodule

// File: rtl/pflash_cmd_if.sv
// Top: connects the sequencer, status register and memory model, and
// registers the read result one cycle after each read strobe.
// Assumes: identifier offsets are shifted by ID_SHIFT (0 or 1); the master
// lock is a fixed strap value given by MASTER_LOCK.
module pflash_cmd_if #(
    parameter int          ADDR_W        = 10,
    parameter int          BLK_OFS_W     = 7,
    parameter int          BUSY_CYC      = 8,
    parameter int          ID_SHIFT      = 0,
    parameter logic [7:0]  MFR_CODE      = 8'h89,
    parameter logic [7:0]  DEV_CODE      = 8'hAD,
    parameter logic [7:0]  INIT_XOR      = 8'hA5,
    parameter bit          MASTER_LOCK   = 1'b0,
    parameter logic [2**(ADDR_W-BLK_OFS_W)-1:0] INIT_BLK_LOCK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rd_valid
);
    import pflash_pkg::*;

    localparam int NUM_BLK = 2 ** (ADDR_W - BLK_OFS_W);
    localparam logic [ADDR_W-1:0]    ID_MFR_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0]    ID_DEV_A = ADDR_W'(1 << ID_SHIFT);
    localparam logic [ADDR_W-1:0]    ID_MST_A = ADDR_W'(3 << ID_SHIFT);
    localparam logic [BLK_OFS_W-1:0] ID_BLK_O = BLK_OFS_W'(2 << ID_SHIFT);

    rd_mode_e           mode;
    logic               busy;
    logic               prog_we, erase_we, lock_clr;
    logic [ADDR_W-1:0]  prog_addr, erase_addr;
    logic [7:0]         prog_data;
    logic               clr_err, set_erase_err, set_prog_err, set_lock_err;
    logic [NUM_BLK-1:0] blk_locked;
    logic [7:0]         status, arr_byte, id_byte, rd_src;
    logic               master_locked;

    assign master_locked = MASTER_LOCK;

    pflash_seq #(
        .ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W), .BUSY_CYC(BUSY_CYC), .NUM_BLK(NUM_BLK)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .blk_locked(blk_locked), .master_locked(master_locked),
        .mode(mode), .busy(busy),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_we(erase_we), .erase_addr(erase_addr), .lock_clr(lock_clr),
        .clr_err(clr_err), .set_erase_err(set_erase_err),
        .set_prog_err(set_prog_err), .set_lock_err(set_lock_err)
    );

    pflash_status u_status (
        .clk(clk), .rst_n(rst_n), .busy(busy), .clr_err(clr_err),
        .set_erase_err(set_erase_err), .set_prog_err(set_prog_err),
        .set_lock_err(set_lock_err), .status(status)
    );

    pflash_array #(
        .ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W), .INIT_XOR(INIT_XOR),
        .NUM_BLK(NUM_BLK), .INIT_BLK_LOCK(INIT_BLK_LOCK)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_byte(arr_byte),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_we(erase_we), .erase_addr(erase_addr), .lock_clr(lock_clr),
        .blk_locked(blk_locked)
    );

    // Identifier space: codes and master lock at fixed addresses, block lock per block.
    always_comb begin
        if (addr == ID_MFR_A)                      id_byte = MFR_CODE;
        else if (addr == ID_DEV_A)                 id_byte = DEV_CODE;
        else if (addr == ID_MST_A)                 id_byte = {7'b0, master_locked};
        else if (addr[BLK_OFS_W-1:0] == ID_BLK_O)  id_byte = {7'b0, blk_locked[addr[ADDR_W-1:BLK_OFS_W]]};
        else                                       id_byte = 8'h00;
    end

    // Read source selected by the current read mode.
    always_comb begin
        case (mode)
            MODE_ARRAY: rd_src = arr_byte;
            MODE_ID:    rd_src = id_byte;
            default:    rd_src = status;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_src;
        end
    end

    assert_busy_read_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rd_valid && !rdata[7]));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rdata)));

endmodule

// File: tb/pflash_cmd_if_tb.sv
// Scoreboard bench: driver tasks queue expected read bytes; a monitor pops
// and compares each result as it leaves the design. Two instances: u_dut
// (master clear, block 2 locked, unshifted ids) and u_dut_ml (master set,
// blocks 0 and 7 locked, shifted ids).
module pflash_cmd_if_tb;

    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          wr_en_t [2];
    logic          rd_en_t [2];
    logic [AW-1:0] addr_t  [2];
    logic [7:0]    wdata_t [2];
    logic [7:0]    rdata_t [2];
    logic          rd_valid_t [2];

    pflash_cmd_if #(
        .ADDR_W(AW), .BLK_OFS_W(7), .BUSY_CYC(8), .ID_SHIFT(0),
        .MASTER_LOCK(1'b0), .INIT_BLK_LOCK(8'b0000_0100)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_t[0]), .rd_en(rd_en_t[0]),
        .addr(addr_t[0]), .wdata(wdata_t[0]), .rdata(rdata_t[0]), .rd_valid(rd_valid_t[0])
    );

    pflash_cmd_if #(
        .ADDR_W(AW), .BLK_OFS_W(7), .BUSY_CYC(8), .ID_SHIFT(1),
        .MASTER_LOCK(1'b1), .INIT_BLK_LOCK(8'b1000_0001)
    ) u_dut_ml (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_t[1]), .rd_en(rd_en_t[1]),
        .addr(addr_t[1]), .wdata(wdata_t[1]), .rdata(rdata_t[1]), .rd_valid(rd_valid_t[1])
    );

    logic [7:0] exp_q0 [$];
    logic [7:0] exp_q1 [$];
    string      tag_q0 [$];
    string      tag_q1 [$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [7:0] init_byte(int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    task automatic wr(int d, int a, logic [7:0] v);
        @(posedge clk); #1;
        wr_en_t[d] = 1'b1; addr_t[d] = AW'(a); wdata_t[d] = v;
        @(posedge clk); #1;
        wr_en_t[d] = 1'b0;
    endtask

    task automatic rd(int d, int a, logic [7:0] e, string tag);
        @(posedge clk); #1;
        rd_en_t[d] = 1'b1; addr_t[d] = AW'(a);
        if (d == 0) begin exp_q0.push_back(e); tag_q0.push_back(tag); end
        else        begin exp_q1.push_back(e); tag_q1.push_back(tag); end
        @(posedge clk); #1;
        rd_en_t[d] = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic compare(logic [7:0] act, logic [7:0] e, string tag);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, e);
        end
    endtask

    // Monitor: pops the expected byte for every valid read of each instance.
    always @(negedge clk) begin
        if (rst_n && rd_valid_t[0]) begin
            if (exp_q0.size() == 0) compare(rdata_t[0], 8'hxx, "R2 unexpected read");
            else compare(rdata_t[0], exp_q0.pop_front(), tag_q0.pop_front());
        end
        if (rst_n && rd_valid_t[1]) begin
            if (exp_q1.size() == 0) compare(rdata_t[1], 8'hxx, "R2 unexpected read");
            else compare(rdata_t[1], exp_q1.pop_front(), tag_q1.pop_front());
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            wr_en_t[d] = 1'b0; rd_en_t[d] = 1'b0; addr_t[d] = '0; wdata_t[d] = 8'h00;
        end
        idle(3);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: reset content and status
        rd(0, 'h005, init_byte('h005), "R1 array reset");
        rd(0, 'h3FF, init_byte('h3FF), "R1 array reset top");
        wr(0, 0, 8'h70);
        rd(0, 0, 8'h80, "R1 R5 status after reset");
        wr(0, 0, 8'hFF);
        rd(0, 'h005, init_byte('h005), "R2 back to array");

        // R3 / R4: identifier space
        wr(0, 0, 8'h90);
        rd(0, 0, 8'h89, "R3 manufacturer");
        rd(0, 1, 8'hAD, "R3 device");
        rd(0, 'h010, 8'h00, "R3 empty id address");
        rd(0, 3, 8'h00, "R4 master clear");
        rd(0, 'h102, 8'h01, "R4 block2 locked");
        rd(0, 'h082, 8'h00, "R4 block1 clear");
        // R13: unknown opcode leaves the mode
        wr(0, 0, 8'h33);
        rd(0, 0, 8'h89, "R13 unknown opcode");
        wr(0, 0, 8'hFF);

        // R8 / R9: program with an ignored write while busy
        wr(0, 'h00C, 8'h40);
        wr(0, 'h00C, 8'h3C);
        rd(0, 0, 8'h00, "R9 busy during program");
        wr(0, 0, 8'hFF);
        idle(12);
        rd(0, 0, 8'h80, "R9 write ignored while busy");
        wr(0, 0, 8'hFF);
        rd(0, 'h00C, init_byte('h00C) & 8'h3C, "R8 program AND");

        // R7: erase block 1
        wr(0, 'h090, 8'h20);
        wr(0, 'h090, 8'hD0);
        rd(0, 'h090, 8'h00, "R7 R9 busy during erase");
        idle(140);
        rd(0, 'h090, 8'h80, "R7 ready after erase");
        wr(0, 0, 8'hFF);
        rd(0, 'h080, 8'hFF, "R7 block start");
        rd(0, 'h0C3, 8'hFF, "R7 block middle");
        rd(0, 'h0FF, 8'hFF, "R7 block end");
        rd(0, 'h07F, init_byte('h07F), "R7 lower neighbour");
        rd(0, 'h100, init_byte('h100), "R7 upper neighbour");

        // R10 / R6: sequence errors and clearing
        wr(0, 'h010, 8'h20);
        wr(0, 'h010, 8'h11);
        rd(0, 0, 8'hB0, "R10 erase bad confirm");
        wr(0, 0, 8'hFF);
        rd(0, 'h010, init_byte('h010), "R10 array untouched");
        wr(0, 0, 8'h50);
        rd(0, 'h010, init_byte('h010), "R6 clear keeps array mode");
        wr(0, 0, 8'h70);
        rd(0, 0, 8'h80, "R6 errors cleared");
        wr(0, 0, 8'h60);
        wr(0, 0, 8'h00);
        rd(0, 0, 8'hB0, "R10 lock clear bad confirm");
        wr(0, 0, 8'h90);
        rd(0, 'h102, 8'h01, "R10 locks kept");
        wr(0, 0, 8'h50);

        // R11: locked block
        wr(0, 'h105, 8'h40);
        wr(0, 'h105, 8'h00);
        rd(0, 0, 8'h92, "R11 program locked");
        wr(0, 0, 8'h50);
        wr(0, 'h110, 8'h20);
        wr(0, 'h110, 8'hD0);
        rd(0, 0, 8'hA2, "R11 erase locked");
        wr(0, 0, 8'hFF);
        rd(0, 'h105, init_byte('h105), "R11 program left array");
        rd(0, 'h110, init_byte('h110), "R11 erase left array");

        // R12: lock clear, master clear
        wr(0, 0, 8'h50);
        wr(0, 0, 8'h60);
        wr(0, 0, 8'hD0);
        rd(0, 0, 8'h00, "R12 busy during lock clear");
        idle(12);
        rd(0, 0, 8'h80, "R12 lock clear done");
        wr(0, 0, 8'h90);
        rd(0, 'h102, 8'h00, "R12 block2 unlocked");

        // Second instance: shifted ids, master locked
        wr(1, 0, 8'h90);
        rd(1, 0, 8'h89, "R3 shifted manufacturer");
        rd(1, 2, 8'hAD, "R3 shifted device");
        rd(1, 6, 8'h01, "R4 shifted master locked");
        rd(1, 4, 8'h01, "R4 shifted block0 lock");
        rd(1, 'h384, 8'h01, "R4 shifted block7 lock");
        rd(1, 'h084, 8'h00, "R4 shifted block1 clear");
        wr(1, 0, 8'h60);
        wr(1, 0, 8'hD0);
        rd(1, 0, 8'hA2, "R12 master locked refuses");
        wr(1, 0, 8'h90);
        rd(1, 'h384, 8'h01, "R12 locks kept under master");

        idle(4);
        if (exp_q0.size() != 0 || exp_q1.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: actual %0d pending reads expected 0",
                     exp_q0.size() + exp_q1.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule